// File: doc/BRIEF.md
# Frame Buffer Pixel Write Translator

This block sits between a processor store path and a pixel memory. The processor sees the screen as a two-dimensional map: each pixel owns one 32-bit processor word, and the row and column indices are packed into the byte address. Rows are spaced as if the screen were 1024 pixels wide. The memory behind the block stores the visible 800 by 600 pixels in raster order, two pixels to a 16-bit word, with one byte lane per pixel.

For each accepted store, the block forms the raster pixel number from the column and row. It does this with shifted copies of the row added together, with no multiplier. It then drives the memory word address, a data word with the 4-bit color in the lane of the addressed pixel, and lane enables that update only that pixel. A store whose column or row falls outside the visible area produces a one-cycle flag and no memory write. Stores outside the frame-buffer window are ignored. All outputs are registered, so each result appears one clock after its store.

Top module: `fb_pixel_xlate`

## Requirements
- R1: While `rstN` is low, `memWe`, `coordErr`, `memBe` and `memData` are all zero, and any store presented during reset produces nothing.
- R2: The frame-buffer window is selected by byte-address bits [31:22] equal to 10'h200 (base 0x8000_0000). The row Y is bits [21:12] and the column X is bits [11:2]. The pixel number is X + 800·Y, and `memAddr` is the pixel number shifted right by one.
- R3: A store in the window with X ≥ 800 or Y ≥ 600 raises `coordErr` for exactly one cycle and leaves `memWe` low, `memBe` zero and `memData` zero in that cycle.
- R4: Pixel-number bit 0 picks the lane. An even pixel gives `memBe` = 2'b01 with the color in `memData[3:0]`. An odd pixel gives `memBe` = 2'b10 with the color in `memData[11:8]`. Every other data bit is zero.
- R5: The result of a store sampled at one rising edge is present for exactly the following cycle. In a cycle with no store, `memWe` and `coordErr` are low and `memBe` and `memData` are zero.
- R6: A store whose bits [31:22] differ from 10'h200 raises neither `memWe` nor `coordErr`.
- R7: Byte-address bits [1:0] have no effect on any output.
- R8: The extreme visible pixels translate exactly: (0,0) to address 0, even lane; (799,599) to address 239999, odd lane. Stores on consecutive cycles each give their own result with no gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Processor store strobe |
| wrAddr | input | 32 | Processor byte address |
| wrColor | input | 4 | Pixel color |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 19 | Memory word address |
| memData | output | 16 | Memory write data, two byte lanes |
| memBe | output | 2 | Byte-lane write enables |
| coordErr | output | 1 | Store fell outside the visible area |

## Verification
A valid write and an out-of-area flag come from the same decode, so on consecutive cycles the block may have to produce one right after the other. The bench drives back-to-back stores that alternate between visible and invisible coordinates, and mixes in stores outside the window. It checks each cycle against a queued expectation, so the flag and the write strobe must each land in their own cycle and never together. A checker also holds the two strobes mutually exclusive, and requires exactly one enabled lane on every write.

// File: rtl/fbx_pkg.sv
package fbx_pkg;

  // Strobes from the decode stage to the datapath registers.
  typedef struct packed {
    logic capture;   // a store inside the frame-buffer window
    logic doWrite;   // store lands on a visible pixel
    logic badCoord;  // store lands outside the visible area
  } xlateStrobes_t;

endpackage

// File: rtl/fbx_ctrl.sv
module fbx_ctrl
  import fbx_pkg::*;
#(
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int TAG_W   = 10,
  parameter int VIS_W   = 800,
  parameter int VIS_H   = 600,
  parameter logic [TAG_W-1:0] WINDOW_TAG = 10'h200
) (
  input  logic             wrValid,
  input  logic [TAG_W-1:0] regionTag,
  input  logic [X_W-1:0]   xCoord,
  input  logic [Y_W-1:0]   yCoord,
  output xlateStrobes_t    strobes
);

  localparam logic [X_W-1:0] X_LIMIT = X_W'(VIS_W);
  localparam logic [Y_W-1:0] Y_LIMIT = Y_W'(VIS_H);

  logic inWindow;
  logic visible;

  always_comb begin
    inWindow         = (regionTag == WINDOW_TAG);
    visible          = (xCoord < X_LIMIT) && (yCoord < Y_LIMIT);
    strobes.capture  = wrValid && inWindow;
    strobes.doWrite  = wrValid && inWindow && visible;
    strobes.badCoord = wrValid && inWindow && !visible;
  end

endmodule

// File: rtl/fbx_datapath.sv
module fbx_datapath
  import fbx_pkg::*;
#(
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int VIS_W   = 800,
  parameter int COLOR_W = 4,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 19
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  xlateStrobes_t        strobes,
  input  logic [X_W-1:0]       xCoord,
  input  logic [Y_W-1:0]       yCoord,
  input  logic [COLOR_W-1:0]   color,
  output logic                 memWe,
  output logic [ADDR_W-1:0]    memAddr,
  output logic [2*LANE_W-1:0]  memData,
  output logic [1:0]           memBe,
  output logic                 coordErr
);

  localparam int NUM_LANES = 2;
  localparam int PN_W      = ADDR_W + 1;
  localparam logic [PN_W-1:0] ROW_PITCH = PN_W'(VIS_W);

  logic [PN_W-1:0] yExt;
  logic [PN_W-1:0] rowTerm [PN_W];
  logic [PN_W-1:0] rowBase;
  logic [PN_W-1:0] pixelNum;
  logic [2*LANE_W-1:0]  laneData;
  logic [NUM_LANES-1:0] laneSel;

  assign yExt = PN_W'(yCoord);

  // One shifted copy of the row for each set bit of the row pitch.
  for (genvar b = 0; b < PN_W; b++) begin : g_rowTerm
    if (ROW_PITCH[b]) begin : g_on
      assign rowTerm[b] = yExt << b;
    end else begin : g_off
      assign rowTerm[b] = '0;
    end
  end

  always_comb begin
    rowBase = '0;
    for (int b = 0; b < PN_W; b++) begin
      rowBase = rowBase + rowTerm[b];
    end
    pixelNum = rowBase + PN_W'(xCoord);
  end

  // Lane steering: pixel-number bit 0 picks the lane.
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    assign laneSel[l] = (pixelNum[0] == l[0]);
    assign laneData[l*LANE_W +: LANE_W] =
      laneSel[l] ? LANE_W'(color) : '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      memWe    <= 1'b0;
      coordErr <= 1'b0;
      memAddr  <= '0;
      memData  <= '0;
      memBe    <= '0;
    end else begin
      memWe    <= strobes.doWrite;
      coordErr <= strobes.badCoord;
      if (strobes.capture && strobes.doWrite) begin
        memAddr <= pixelNum[PN_W-1:1];
        memData <= laneData;
        memBe   <= laneSel;
      end else begin
        memData <= '0;
        memBe   <= '0;
      end
    end
  end

endmodule

// File: rtl/fb_pixel_xlate.sv
module fb_pixel_xlate
  import fbx_pkg::*;
#(
  parameter int X_W     = 10,
  parameter int Y_W     = 10,
  parameter int VIS_W   = 800,
  parameter int VIS_H   = 600,
  parameter int COLOR_W = 4,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 19
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrValid,
  input  logic [31:0]         wrAddr,
  input  logic [COLOR_W-1:0]  wrColor,
  output logic                memWe,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [2*LANE_W-1:0] memData,
  output logic [1:0]          memBe,
  output logic                coordErr
);

  localparam int X_LSB = 2;
  localparam int Y_LSB = X_LSB + X_W;
  localparam int TAG_LSB = Y_LSB + Y_W;
  localparam int TAG_W = 32 - TAG_LSB;

  xlateStrobes_t      strobes;
  logic [X_W-1:0]     xCoord;
  logic [Y_W-1:0]     yCoord;
  logic [TAG_W-1:0]   regionTag;
  logic               unusedLowBits;

  assign xCoord        = wrAddr[X_LSB +: X_W];
  assign yCoord        = wrAddr[Y_LSB +: Y_W];
  assign regionTag     = wrAddr[31:TAG_LSB];
  assign unusedLowBits = ^wrAddr[X_LSB-1:0];

  fbx_ctrl #(
    .X_W(X_W), .Y_W(Y_W), .TAG_W(TAG_W), .VIS_W(VIS_W), .VIS_H(VIS_H),
    .WINDOW_TAG(TAG_W'(10'h200))
  ) u_ctrl (
    .wrValid  (wrValid),
    .regionTag(regionTag),
    .xCoord   (xCoord),
    .yCoord   (yCoord),
    .strobes  (strobes)
  );

  fbx_datapath #(
    .X_W(X_W), .Y_W(Y_W), .VIS_W(VIS_W), .COLOR_W(COLOR_W),
    .LANE_W(LANE_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .xCoord  (xCoord),
    .yCoord  (yCoord),
    .color   (wrColor),
    .memWe   (memWe),
    .memAddr (memAddr),
    .memData (memData),
    .memBe   (memBe),
    .coordErr(coordErr)
  );

endmodule

// File: rtl/fbx_checker.sv
module fbx_checker #(
  parameter int COLOR_W = 4,
  parameter int LANE_W  = 8,
  parameter int ADDR_W  = 19,
  parameter int VIS_W   = 800,
  parameter int VIS_H   = 600
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrValid,
  input logic [31:0]         wrAddr,
  input logic                memWe,
  input logic [ADDR_W-1:0]   memAddr,
  input logic [2*LANE_W-1:0] memData,
  input logic [1:0]          memBe,
  input logic                coordErr
);

  localparam int WORDS = (VIS_W * VIS_H) / 2;

  // R3: flag and write never share a cycle
  a_r3_no_write_with_flag: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && coordErr));

  // R4: exactly one lane enabled on a write
  a_r4_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> ($countones(memBe) == 1));

  // R4: even lane carries nothing above the color nibble
  a_r4_even_lane_clean: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memBe[0]) |-> (memData[2*LANE_W-1:COLOR_W] == '0));

  // R5: a write follows a store one cycle earlier
  a_r5_write_after_store: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> $past(wrValid));

  // R5: a flag follows a store one cycle earlier
  a_r5_flag_after_store: assert property (@(posedge clk) disable iff (!rstN)
    coordErr |-> $past(wrValid));

  // R6: a store outside the window yields nothing
  a_r6_outside_window: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && (wrAddr[31:22] != 10'h200)) |=> (!memWe && !coordErr));

  // R2: write address stays inside the visible words
  a_r2_addr_bound: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (int'(memAddr) < WORDS));

  // R5: no enables without a write
  a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !memWe |-> (memBe == 2'b00));

endmodule

bind fb_pixel_xlate fbx_checker #(
  .COLOR_W(COLOR_W), .LANE_W(LANE_W), .ADDR_W(ADDR_W),
  .VIS_W(VIS_W), .VIS_H(VIS_H)
) u_fbx_checker (
  .clk     (clk),
  .rstN    (rstN),
  .wrValid (wrValid),
  .wrAddr  (wrAddr),
  .memWe   (memWe),
  .memAddr (memAddr),
  .memData (memData),
  .memBe   (memBe),
  .coordErr(coordErr)
);

// File: tb/test_fb_pixel_xlate.sv
module test_fb_pixel_xlate;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrAddr = '0;
  logic [3:0]  wrColor = '0;
  logic        memWe;
  logic [18:0] memAddr;
  logic [15:0] memData;
  logic [1:0]  memBe;
  logic        coordErr;

  int checks = 0;
  int fails = 0;

  typedef struct {
    bit          we;
    bit          err;
    int          addr;
    bit [1:0]    be;
    bit [15:0]   data;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  fb_pixel_xlate i_fb_pixel_xlate (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrColor(wrColor), .memWe(memWe), .memAddr(memAddr),
    .memData(memData), .memBe(memBe), .coordErr(coordErr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Driver: raw store; expectation derived from the requirements.
  task automatic storeRaw(input logic [31:0] a, input logic [3:0] c, input string tag);
    expItem_t e;
    int x, y, pn;
    @(negedge clk);
    wrValid = 1'b1;
    wrAddr  = a;
    wrColor = c;
    x = int'(a[11:2]);
    y = int'(a[21:12]);
    e.tag = tag; e.we = 0; e.err = 0; e.addr = 0; e.be = 2'b00; e.data = '0;
    if (a[31:22] == 10'h200) begin
      if (x >= 800 || y >= 600) begin
        e.err = 1;
      end else begin
        pn = x + 800 * y;
        e.we = 1;
        e.addr = pn / 2;
        if (pn % 2 == 0) begin e.be = 2'b01; e.data = {12'h000, c}; end
        else             begin e.be = 2'b10; e.data = {4'h0, c, 8'h00}; end
      end
    end
    expQ.push_back(e);
  endtask

  task automatic storePix(input int x, input int y, input logic [3:0] c,
                          input logic [1:0] low, input string tag);
    storeRaw(32'h8000_0000 | (32'(y) << 12) | (32'(x) << 2) | 32'(low), c, tag);
  endtask

  task automatic idle(input string tag);
    expItem_t e;
    @(negedge clk);
    wrValid = 1'b0;
    wrAddr  = 32'h8000_0000;
    wrColor = 4'hF;
    e.tag = tag; e.we = 0; e.err = 0; e.addr = 0; e.be = 2'b00; e.data = '0;
    expQ.push_back(e);
  endtask

  // Monitor: compare one cycle after each driven cycle.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (memWe !== e.we || coordErr !== e.err || memBe !== e.be ||
            memData !== e.data || (e.we && int'(memAddr) != e.addr)) begin
          fails++;
          $display("FAIL %s: got we=%0b err=%0b addr=%0d be=%b data=%h, expected we=%0b err=%0b addr=%0d be=%b data=%h",
                   e.tag, memWe, coordErr, memAddr, memBe, memData,
                   e.we, e.err, e.addr, e.be, e.data);
        end
      end
    end
  end

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: got timeout, expected completion");
    finishRun();
  end

  initial begin
    logic [15:0] lfsr;
    // R1: store held during reset must produce nothing
    wrValid = 1'b1;
    wrAddr  = 32'h8000_1004;
    wrColor = 4'hA;
    repeat (3) @(negedge clk);
    checks++;
    if (memWe !== 1'b0 || coordErr !== 1'b0 || memBe !== 2'b00 || memData !== 16'h0) begin
      fails++;
      $display("FAIL R1: got we=%0b err=%0b be=%b data=%h, expected all zero",
               memWe, coordErr, memBe, memData);
    end
    wrValid = 1'b0;
    rstN = 1'b1;
    idle("R1 first cycle after reset");

    // R2 / R4 / R8: corners and lanes
    storePix(0, 0, 4'h5, 2'b00, "R8 origin");
    storePix(1, 0, 4'hC, 2'b00, "R4 odd lane");
    storePix(799, 599, 4'h9, 2'b00, "R8 last pixel");
    storePix(798, 599, 4'h3, 2'b00, "R4 even lane last row");
    storePix(799, 0, 4'h7, 2'b00, "R2 row end");
    storePix(0, 1, 4'h1, 2'b00, "R2 row pitch");
    storePix(0, 599, 4'hE, 2'b00, "R2 last row start");
    storePix(123, 456, 4'hB, 2'b00, "R2 interior");
    idle("R5 idle gap");

    // R3: out-of-area coordinates
    storePix(800, 0, 4'h2, 2'b00, "R3 x at limit");
    storePix(0, 600, 4'h2, 2'b00, "R3 y at limit");
    storePix(1023, 1023, 4'h2, 2'b00, "R3 both max");
    idle("R3 flag lasts one cycle");

    // R6: outside the window
    storeRaw(32'h8040_0040, 4'h6, "R6 other region");
    storeRaw(32'h0000_1004, 4'h6, "R6 low region");
    storeRaw(32'hC000_0000, 4'h6, "R6 high region");

    // R7: low address bits ignored
    storePix(10, 20, 4'hD, 2'b11, "R7 low bits 11");
    storePix(11, 20, 4'hD, 2'b01, "R7 low bits 01");

    // R5 / R3: alternate visible and invisible stores back to back
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) storePix(i * 37, i * 29, 4'(i), 2'(i), "R5 alternate visible");
      else            storePix(800 + i, i, 4'(i), 2'b00, "R3 alternate invisible");
    end

    // R2 / R4: pseudo-random sweep over the whole address field
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      int x, y;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x = int'(lfsr[9:0]);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      y = int'(lfsr[9:0]);
      if (lfsr[0]) idle("R5 random idle");
      else storePix(x, y, lfsr[7:4], lfsr[3:2], "R2 random sweep");
    end

    idle("R5 flush");
    @(negedge clk);
    @(negedge clk);
    finishRun();
  end

endmodule